// File: doc/BRIEF.md
# Fault Rollback and Replacement Controller

This block supervises a set of replaceable functional units. When the program issues an instruction, the controller starts it with a one-cycle synchronisation pulse. It then watches the units named in the instruction's expected-unit map until each one reports completion. While the instruction runs, it treats any of these as a fault: an internal-fault report, activity from a unit the map does not name, an error line from a bus checker, or a completion that never arrives.

Recovery follows a retry-then-replace policy. On the first fault attributed to a unit, the controller resets every unit and requests a rollback to the address the program last stored as its rollback point. If the same unit is blamed again before the program moves that point, the fault is taken as permanent. The controller then sends a change-position pulse to that unit's power switch and waits for the switch status line to flip. It then consumes one of the unit's spares, resets all units and rolls back again. When no spare is left, or a switch never confirms, the controller enters a sticky fatal state. A power-loss input holds every unit in reset and then forces a rollback.

Top module: `fru_rollback_ctl`

## Requirements
- R1: After reset, `idle` is 1, `rb_addr` is 0 and every other output is 0.
- R2: `instr_go` sampled while idle latches `exp_map`. `sync` is high in the following cycle only. `instr_done` then pulses for one cycle, one cycle after the clock edge at which every unit set in `exp_map` has shown `unit_complete`. Completions may arrive in different cycles.
- R3: While an instruction runs, a fault is any of these: a set `unit_fault` bit, a `unit_active` bit outside the map, a set `chk_err` bit, or `CMPL_TMO` running cycles without all completions. The controller reacts to a timeout in the response to the `CMPL_TMO`-th running cycle.
- R4: A fault not classed as a repeat gives a one-cycle `rb_req`, with `unit_reset` all ones in the same cycle, and then a return to idle.
- R5: `rb_addr` changes only one cycle after `rbp_load` and then equals the loaded `rbp_addr`.
- R6: A repeat fault is a second fault blamed on the same unit index (0 to N_UNITS-1) before any `rbp_load`. It gives a one-cycle pulse on that unit's `sw_toggle` bit only. Once `sw_pos` of that unit differs from its value at the fault, the controller issues `rb_req` with all resets.
- R7: Each unit starts with `SPARES` spares. A confirmed replacement consumes one. A repeat fault on a unit with none left raises `fatal` without a toggle, and `fatal` stays high until reset, ignoring `instr_go`.
- R8: If the switch status does not change within `SW_TMO` cycles after the toggle, `fatal` is raised.
- R9: `rbp_load` and a confirmed replacement both clear the record of the last faulting unit, so the next fault is handled as in R4.
- R10: While `pwr_fail` is high in any non-fatal state, all `unit_reset` bits are held high from the next cycle on, with no `rb_req`. After `pwr_fail` falls, one `rb_req` follows.
- R11: Blame priority: the lowest-index `unit_fault` first, then the lowest-index unexpected `unit_active`, then any checker error, then the lowest-index expected unit still missing. Checker errors are blamed on code N_UNITS, which never leads to a replacement.
- R12: `instr_go` has no effect unless the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_go | input | 1 | Start the current instruction |
| exp_map | input | N_UNITS | Units expected to take part in the instruction |
| unit_active | input | N_UNITS | Per-unit activity status |
| unit_complete | input | N_UNITS | Per-unit completion status |
| unit_fault | input | N_UNITS | Per-unit internal fault status |
| chk_err | input | N_CHK | Bus checker error lines |
| sw_pos | input | N_UNITS | Power switch position status per unit |
| rbp_load | input | 1 | Program write strobe for the rollback point |
| rbp_addr | input | ADDR_W | Rollback point value to store |
| pwr_fail | input | 1 | Catastrophic transient (power loss) indication |
| idle | output | 1 | Ready to accept an instruction |
| sync | output | 1 | Instruction synchronisation pulse |
| instr_done | output | 1 | Instruction completed cleanly |
| rb_req | output | 1 | Rollback request |
| rb_addr | output | ADDR_W | Address to restart at |
| unit_reset | output | N_UNITS | Per-unit reset to the standard state |
| sw_toggle | output | N_UNITS | Per-unit power switch change-position pulse |
| fatal | output | 1 | Unrecoverable condition, sticky |

## Verification
The bench tries each fault source alone: an internal fault, stray activity, a checker error and a missing completion, with a sample taken just before and at the timeout edge. Two sources are also driven together, and a later repeat on only one of them shows which unit the controller blamed. Fault sequences on the same unit are interleaved with rollback-point loads, which separates a transient retry from a permanent replacement. Further sequences separate a confirmed switch from a stuck switch or an exhausted spare pool. A power-loss pulse during an instruction checks that the held resets are kept apart from the later rollback.

// File: rtl/fru_ctl_pkg.sv
package fru_ctl_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SYNC,
      ST_RUN,
      ST_DONE,
      ST_RECOVER,
      ST_TOGGLE,
      ST_SWWAIT,
      ST_HOLD,
      ST_FATAL
   } ctl_state_t;

endpackage

// File: rtl/fru_timeout.sv
module fru_timeout #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   output logic expired
);
   localparam int CW = $clog2(LIMIT + 1);

   initial begin
      assert (LIMIT >= 2) else $error("fru_timeout: LIMIT must be at least 2");
   end

   logic [CW-1:0] cnt;

   assign expired = run && (cnt == CW'(LIMIT - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)                cnt <= '0;
      else if (clr)              cnt <= '0;
      else if (run && !expired)  cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/fru_fault_arb.sv
module fru_fault_arb #(
   parameter int N_UNITS = 4,
   parameter int N_CHK   = 2,
   parameter int IDW     = 3
) (
   input  logic [N_UNITS-1:0] int_flt,
   input  logic [N_UNITS-1:0] act,
   input  logic [N_UNITS-1:0] exp_map,
   input  logic [N_UNITS-1:0] seen,
   input  logic [N_CHK-1:0]   chk,
   input  logic               tmo,
   output logic               hit,
   output logic [IDW-1:0]     id
);
   logic [N_UNITS-1:0] unexp;
   logic [N_UNITS-1:0] miss;

   assign unexp = act & ~exp_map;
   assign miss  = exp_map & ~seen;

   always_comb begin
      hit = 1'b0;
      id  = IDW'(N_UNITS);
      if (|int_flt) begin
         hit = 1'b1;
         for (int i = N_UNITS - 1; i >= 0; i--) if (int_flt[i]) id = IDW'(i);
      end else if (|unexp) begin
         hit = 1'b1;
         for (int i = N_UNITS - 1; i >= 0; i--) if (unexp[i]) id = IDW'(i);
      end else if (|chk) begin
         hit = 1'b1;
      end else if (tmo) begin
         hit = 1'b1;
         for (int i = N_UNITS - 1; i >= 0; i--) if (miss[i]) id = IDW'(i);
      end
   end
endmodule

// File: rtl/fru_spare_ledger.sv
module fru_spare_ledger #(
   parameter int N_UNITS = 4,
   parameter int SPARES  = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_UNITS-1:0] use_spare,
   output logic [N_UNITS-1:0] has_spare
);
   initial begin
      assert (SPARES >= 1) else $error("fru_spare_ledger: SPARES must be at least 1");
   end

   for (genvar g = 0; g < N_UNITS; g++) begin : g_unit
      if (SPARES == 1) begin : g_flag
         logic avail;
         always_ff @(posedge clk) begin
            if (!rst_n)            avail <= 1'b1;
            else if (use_spare[g]) avail <= 1'b0;
         end
         assign has_spare[g] = avail;
      end else begin : g_count
         localparam int SW = $clog2(SPARES + 1);
         logic [SW-1:0] left;
         always_ff @(posedge clk) begin
            if (!rst_n)                          left <= SW'(SPARES);
            else if (use_spare[g] && left != 0)  left <= left - 1'b1;
         end
         assign has_spare[g] = (left != '0);
      end
   end
endmodule

// File: rtl/fru_rollback_ctl.sv
module fru_rollback_ctl
   import fru_ctl_pkg::*;
#(
   parameter int N_UNITS  = 4,
   parameter int N_CHK    = 2,
   parameter int ADDR_W   = 16,
   parameter int SPARES   = 1,
   parameter int CMPL_TMO = 20,
   parameter int SW_TMO   = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                instr_go,
   input  logic [N_UNITS-1:0]  exp_map,
   input  logic [N_UNITS-1:0]  unit_active,
   input  logic [N_UNITS-1:0]  unit_complete,
   input  logic [N_UNITS-1:0]  unit_fault,
   input  logic [N_CHK-1:0]    chk_err,
   input  logic [N_UNITS-1:0]  sw_pos,
   input  logic                rbp_load,
   input  logic [ADDR_W-1:0]   rbp_addr,
   input  logic                pwr_fail,
   output logic                idle,
   output logic                sync,
   output logic                instr_done,
   output logic                rb_req,
   output logic [ADDR_W-1:0]   rb_addr,
   output logic [N_UNITS-1:0]  unit_reset,
   output logic [N_UNITS-1:0]  sw_toggle,
   output logic                fatal
);
   localparam int IDW = $clog2(N_UNITS + 1);
   localparam int UW  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1;
   localparam logic [IDW-1:0] CHK_ID = IDW'(N_UNITS);

   initial begin
      assert (N_UNITS >= 2) else $error("fru_rollback_ctl: N_UNITS must be at least 2");
      assert (N_CHK >= 1)   else $error("fru_rollback_ctl: N_CHK must be at least 1");
   end

   ctl_state_t          state;
   logic [N_UNITS-1:0]  exp_q, seen_q, seen_nx;
   logic [ADDR_W-1:0]   rbp_q;
   logic                lf_vld;
   logic [IDW-1:0]      lf_id;
   logic [UW-1:0]       tgt;
   logic                pos_old;
   logic                all_done, cmpl_exp, sw_exp, sw_ok;
   logic                flt_hit, repeat_flt;
   logic [IDW-1:0]      flt_id;
   logic [N_UNITS-1:0]  has_spare, use_spare;

   assign seen_nx  = seen_q | (unit_complete & exp_q);
   assign all_done = ((seen_nx & exp_q) == exp_q);
   assign sw_ok    = (sw_pos[tgt] != pos_old);

   fru_timeout #(.LIMIT(CMPL_TMO)) u_cmpl_tmo (
      .clk(clk), .rst_n(rst_n), .clr(state == ST_SYNC),
      .run(state == ST_RUN), .expired(cmpl_exp));

   fru_timeout #(.LIMIT(SW_TMO)) u_sw_tmo (
      .clk(clk), .rst_n(rst_n), .clr(state == ST_TOGGLE),
      .run(state == ST_SWWAIT), .expired(sw_exp));

   fru_fault_arb #(.N_UNITS(N_UNITS), .N_CHK(N_CHK), .IDW(IDW)) u_arb (
      .int_flt(unit_fault), .act(unit_active), .exp_map(exp_q),
      .seen(seen_nx), .chk(chk_err), .tmo(cmpl_exp && !all_done),
      .hit(flt_hit), .id(flt_id));

   fru_spare_ledger #(.N_UNITS(N_UNITS), .SPARES(SPARES)) u_ledger (
      .clk(clk), .rst_n(rst_n), .use_spare(use_spare), .has_spare(has_spare));

   assign repeat_flt = lf_vld && !rbp_load && (lf_id == flt_id) && (flt_id != CHK_ID);

   always_comb begin
      use_spare = '0;
      sw_toggle = '0;
      for (int i = 0; i < N_UNITS; i++) begin
         use_spare[i] = (state == ST_SWWAIT) && sw_ok && (tgt == UW'(i));
         sw_toggle[i] = (state == ST_TOGGLE) && (tgt == UW'(i));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         exp_q   <= '0;
         seen_q  <= '0;
         rbp_q   <= '0;
         lf_vld  <= 1'b0;
         lf_id   <= '0;
         tgt     <= '0;
         pos_old <= 1'b0;
      end else begin
         if (rbp_load) begin
            rbp_q  <= rbp_addr;
            lf_vld <= 1'b0;
         end
         if (pwr_fail && state != ST_FATAL) begin
            state <= ST_HOLD;
         end else begin
            case (state)
               ST_IDLE: if (instr_go) begin
                  exp_q <= exp_map;
                  state <= ST_SYNC;
               end
               ST_SYNC: begin
                  seen_q <= '0;
                  state  <= ST_RUN;
               end
               ST_RUN: begin
                  seen_q <= seen_nx;
                  if (flt_hit) begin
                     lf_vld <= 1'b1;
                     lf_id  <= flt_id;
                     if (!repeat_flt) begin
                        state <= ST_RECOVER;
                     end else if (has_spare[flt_id[UW-1:0]]) begin
                        tgt     <= flt_id[UW-1:0];
                        pos_old <= sw_pos[flt_id[UW-1:0]];
                        state   <= ST_TOGGLE;
                     end else begin
                        state <= ST_FATAL;
                     end
                  end else if (all_done) begin
                     state <= ST_DONE;
                  end
               end
               ST_TOGGLE: state <= ST_SWWAIT;
               ST_SWWAIT: begin
                  if (sw_ok) begin
                     lf_vld <= 1'b0;
                     state  <= ST_RECOVER;
                  end else if (sw_exp) begin
                     state <= ST_FATAL;
                  end
               end
               ST_HOLD:    state <= ST_RECOVER;
               ST_DONE:    state <= ST_IDLE;
               ST_RECOVER: state <= ST_IDLE;
               ST_FATAL:   state <= ST_FATAL;
               default:    state <= ST_IDLE;
            endcase
         end
      end
   end

   assign idle       = (state == ST_IDLE);
   assign sync       = (state == ST_SYNC);
   assign instr_done = (state == ST_DONE);
   assign rb_req     = (state == ST_RECOVER);
   assign rb_addr    = rbp_q;
   assign unit_reset = (state == ST_RECOVER || state == ST_HOLD) ? '1 : '0;
   assign fatal      = (state == ST_FATAL);
endmodule

// File: rtl/fru_rollback_ctl_chk.sv
module fru_rollback_ctl_chk #(
   parameter int N_UNITS = 4,
   parameter int ADDR_W  = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               instr_go,
   input logic               rbp_load,
   input logic               pwr_fail,
   input logic               sync,
   input logic [ADDR_W-1:0]  rb_addr,
   input logic [N_UNITS-1:0] unit_reset,
   input logic [N_UNITS-1:0] sw_toggle,
   input logic               fatal
);
   a_r2_sync_single: assert property (@(posedge clk) disable iff (!rst_n)
      sync |=> !sync);

   a_r12_sync_after_go: assert property (@(posedge clk) disable iff (!rst_n)
      sync |-> $past(instr_go));

   a_r5_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
      !rbp_load |=> $stable(rb_addr));

   a_r6_toggle_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sw_toggle));

   a_r7_fatal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      fatal |=> fatal);

   a_r10_hold_resets: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_fail && !fatal) |=> (&unit_reset));
endmodule

bind fru_rollback_ctl fru_rollback_ctl_chk #(.N_UNITS(N_UNITS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/fru_rollback_ctl_bench.sv
`timescale 1ns/1ps
module fru_rollback_ctl_bench;
   localparam int N   = 4;
   localparam int NC  = 2;
   localparam int AW  = 16;
   localparam int TMO = 20;
   localparam int EV_SYNC = 1, EV_DONE = 2, EV_RB = 3, EV_TOG = 4, EV_FATAL = 5;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          instr_go = 1'b0;
   logic [N-1:0]  exp_map = '0, unit_active = '0, unit_complete = '0, unit_fault = '0;
   logic [NC-1:0] chk_err = '0;
   logic [N-1:0]  sw_pos = '0;
   logic          rbp_load = 1'b0;
   logic [AW-1:0] rbp_addr = '0;
   logic          pwr_fail = 1'b0;
   logic          idle, sync, instr_done, rb_req, fatal;
   logic [AW-1:0] rb_addr;
   logic [N-1:0]  unit_reset, sw_toggle;

   fru_rollback_ctl #(.N_UNITS(N), .N_CHK(NC), .ADDR_W(AW), .SPARES(1),
                      .CMPL_TMO(TMO), .SW_TMO(8)) u_fru_rollback_ctl (.*);

   typedef struct { int kind; int data; string req; } ev_t;
   ev_t expq[$];
   int  n_chk = 0, n_bad = 0;
   bit  sw_stuck = 1'b0, fatal_d = 1'b0, done = 1'b0;
   int  sw_cnt = 0, sw_idx = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   task automatic push(input int k, input int d, input string r);
      ev_t e;
      e.kind = k; e.data = d; e.req = r;
      expq.push_back(e);
   endtask

   task automatic got(input int k, input int d);
      ev_t e;
      if (expq.size() == 0) begin
         check(1'b0, "R12", "unplanned event", k * 65536 + d, 0);
      end else begin
         e = expq.pop_front();
         check(e.kind == k && e.data == d, e.req, "event",
               k * 65536 + d, e.kind * 65536 + e.data);
      end
   endtask

   function automatic int idx_of(input logic [N-1:0] v);
      int r = -1;
      for (int i = 0; i < N; i++) if (v[i]) r = i;
      return r;
   endfunction

   // monitor: pops expected events as the outputs show them
   always @(negedge clk) begin
      if (!rst_n) begin
         fatal_d = 1'b0;
      end else begin
         if (sync)       got(EV_SYNC, 0);
         if (instr_done) got(EV_DONE, 0);
         if (sw_toggle != '0) got(EV_TOG, idx_of(sw_toggle));
         if (rb_req) begin
            got(EV_RB, int'(rb_addr));
            check(unit_reset == '1, "R4", "resets with rollback", int'(unit_reset), 15);
         end
         if (fatal && !fatal_d) got(EV_FATAL, 0);
         fatal_d = fatal;
      end
   end

   // power switch model: flips position three cycles after a toggle
   always @(negedge clk) begin
      if (sw_toggle != '0 && !sw_stuck) begin
         sw_cnt = 3;
         sw_idx = idx_of(sw_toggle);
      end else if (sw_cnt == 1) begin
         sw_pos[sw_idx] = ~sw_pos[sw_idx];
         sw_cnt = 0;
      end else if (sw_cnt > 1) begin
         sw_cnt = sw_cnt - 1;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic start(input logic [N-1:0] e);
      instr_go = 1'b1; exp_map = e;
      tick(1);
      instr_go = 1'b0;
      tick(1);
   endtask

   task automatic fault(input int u);
      unit_fault[u] = 1'b1;
      tick(1);
      unit_fault = '0;
   endtask

   task automatic load_rbp(input logic [AW-1:0] a);
      rbp_load = 1'b1; rbp_addr = a;
      tick(1);
      rbp_load = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tick(2);
      rst_n = 1'b1;
      tick(1);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         check(1'b0, "R1", "watchdog expired", 0, 1);
         summary();
         $finish;
      end
   end

   initial begin
      tick(2);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      check(idle == 1'b1 && sync == 1'b0 && instr_done == 1'b0 && rb_req == 1'b0 &&
            fatal == 1'b0 && unit_reset == '0 && sw_toggle == '0 && rb_addr == '0,
            "R1", "reset outputs", {idle, sync, instr_done, rb_req, fatal}, 16);

      // R2 split completions; R12 go ignored while running
      push(EV_SYNC, 0, "R2"); push(EV_DONE, 0, "R2");
      start(4'b0011);
      unit_complete = 4'b0001; instr_go = 1'b1;
      tick(1);
      unit_complete = 4'b0010; instr_go = 1'b0;
      tick(1);
      unit_complete = '0;
      tick(3);
      check(expq.size() == 0, "R12", "pending events after go while busy", expq.size(), 0);
      check(idle == 1'b1, "R2", "idle after done", idle, 1);

      // R5 rollback point load
      load_rbp(16'h1234);
      check(rb_addr == 16'h1234, "R5", "rb_addr after load", rb_addr, 16'h1234);

      // R4 first fault: rollback only
      push(EV_SYNC, 0, "R3"); push(EV_RB, 16'h1234, "R4");
      start(4'b0011); fault(2); tick(4);

      // R9 new rollback point clears retry memory
      load_rbp(16'h0040);
      push(EV_SYNC, 0, "R9"); push(EV_RB, 16'h0040, "R9");
      start(4'b0011); fault(2); tick(4);

      // R6 repeat fault: replace unit 2
      push(EV_SYNC, 0, "R6"); push(EV_TOG, 2, "R6"); push(EV_RB, 16'h0040, "R6");
      start(4'b0011); fault(2); tick(12);

      // R11 internal fault outranks unexpected activity
      push(EV_SYNC, 0, "R11"); push(EV_RB, 16'h0040, "R11");
      start(4'b0001);
      unit_fault[3] = 1'b1; unit_active = 4'b0010;
      tick(1);
      unit_fault = '0; unit_active = '0;
      tick(4);
      push(EV_SYNC, 0, "R11"); push(EV_TOG, 3, "R11"); push(EV_RB, 16'h0040, "R11");
      start(4'b0001); fault(3); tick(12);

      // R3 unexpected activity alone
      push(EV_SYNC, 0, "R3"); push(EV_RB, 16'h0040, "R3");
      start(4'b0001);
      unit_active = 4'b0100;
      tick(1);
      unit_active = '0;
      tick(4);

      // R3 completion timeout, blamed on missing unit 1
      load_rbp(16'h0100);
      push(EV_SYNC, 0, "R3"); push(EV_RB, 16'h0100, "R3");
      start(4'b0011);
      unit_complete = 4'b0001;
      tick(1);
      unit_complete = '0;
      tick(TMO - 3);
      check(rb_req == 1'b0 && idle == 1'b0, "R3", "early timeout", rb_req, 0);
      tick(2);
      check(rb_req == 1'b1, "R3", "timeout at limit", rb_req, 1);
      tick(4);
      push(EV_SYNC, 0, "R3"); push(EV_TOG, 1, "R3"); push(EV_RB, 16'h0100, "R3");
      start(4'b0011);
      unit_complete = 4'b0001;
      tick(1);
      unit_complete = '0;
      tick(TMO + 14);

      // R11 checker errors never replace
      push(EV_SYNC, 0, "R3"); push(EV_RB, 16'h0100, "R3");
      start(4'b0001);
      chk_err = 2'b01; tick(1); chk_err = '0; tick(4);
      push(EV_SYNC, 0, "R11"); push(EV_RB, 16'h0100, "R11");
      start(4'b0001);
      chk_err = 2'b10; tick(1); chk_err = '0; tick(4);

      // R7 no spare left for unit 2
      load_rbp(16'h0200);
      push(EV_SYNC, 0, "R7"); push(EV_RB, 16'h0200, "R7");
      start(4'b0011); fault(2); tick(4);
      push(EV_SYNC, 0, "R7"); push(EV_FATAL, 0, "R7");
      start(4'b0011); fault(2); tick(4);
      check(fatal == 1'b1 && sw_toggle == '0, "R7", "fatal without toggle", fatal, 1);
      instr_go = 1'b1; tick(1); instr_go = 1'b0; tick(3);
      check(fatal == 1'b1 && sync == 1'b0, "R7", "fatal sticky", fatal, 1);
      check(expq.size() == 0, "R7", "pending events", expq.size(), 0);

      // R8 stuck switch
      do_reset();
      check(fatal == 1'b0 && idle == 1'b1 && rb_addr == '0, "R1", "reset after fatal", fatal, 0);
      sw_stuck = 1'b1;
      push(EV_SYNC, 0, "R8"); push(EV_RB, 0, "R8");
      start(4'b0001); fault(0); tick(4);
      push(EV_SYNC, 0, "R8"); push(EV_TOG, 0, "R8"); push(EV_FATAL, 0, "R8");
      start(4'b0001); fault(0); tick(20);
      check(fatal == 1'b1, "R8", "fatal on unconfirmed switch", fatal, 1);
      sw_stuck = 1'b0;

      // R10 power loss restart
      do_reset();
      push(EV_SYNC, 0, "R10");
      start(4'b0011);
      pwr_fail = 1'b1;
      tick(1);
      check(unit_reset == '1 && rb_req == 1'b0, "R10", "resets held", int'(unit_reset), 15);
      tick(2);
      check(unit_reset == '1 && rb_req == 1'b0, "R10", "resets still held", int'(unit_reset), 15);
      push(EV_RB, 0, "R10");
      pwr_fail = 1'b0;
      tick(4);
      check(idle == 1'b1 && unit_reset == '0, "R10", "idle after restart", idle, 1);

      check(expq.size() == 0, "R2", "events left at end", expq.size(), 0);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule